// File: doc/BRIEF.md
# NAND Flash Host Bus Timing Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus and turns single-step requests into correctly timed strobe sequences. Each request is one bus step: a command byte, an address byte, a data byte written, a data byte read, or a wait for the device's ready line. The sequencer drives chip enable, the command and address latch enables, the write and read strobes and the output enable of the shared data bus, captures read bytes, and watches the ready line.

Every nanosecond minimum is a parameter and is turned into a whole number of clock cycles by rounding up against the clock-period parameter. Beyond plain strobe shaping, the block tracks the time since the last write strobe edge and since the ready line was last seen high, and holds the next step back until the gap that step needs has passed: the long address-to-data gap, the write-to-read turnaround after a command, the latch-to-read delay, the ready-to-read delay, and the settle time before ready may be sampled at all. A wait that sees the ready line low for too long ends with an error flag.

Top module: `nand_seq_top`

## Requirements
- R1: While reset is high and in the cycle after it falls, chip enable is high (inactive), both strobes are high, both latch enables are low, the bus output enable is low and the request port shows ready.
- R2: A request is taken only while the block is idle; from the cycle after a request is taken until the step completes, the ready output is low.
- R3: Op codes are 0 = command, 1 = address, 2 = data write. For these the write strobe is low for max(ceil(15 ns), ceil(10 ns)) cycles (2 at 10 ns), with the command latch enable high only for op 0, the address latch enable high only for op 1, the bus enabled and carrying the request byte; both latch enables and the byte stay unchanged for max(ceil(10 ns), ceil(5 ns)) cycles after the strobe rises.
- R4: A data write that directly follows an address write has its strobe rising edge at least ceil(100 ns) cycles (10) after the address strobe rising edge.
- R5: A read step after a command write lowers the read strobe no earlier than ceil(60 ns) cycles (6) after that command's write strobe rises.
- R6: Op code 3 = data read: the read strobe is low for max(ceil(15 ns), ceil(18 ns)) cycles (2), then high for ceil(10 ns) cycles; the byte on the bus in the last low cycle is returned with the data-valid pulse, together with the done pulse.
- R7: Op code 4 = wait for ready: the ready line is not sampled until ceil(100 ns) cycles (10) after the last write strobe rise; the step then completes with done and no error in the cycle after ready is seen high.
- R8: A read strobe falls no earlier than ceil(20 ns) cycles (2) after a wait step has observed the ready line high.
- R9: If a wait step samples the ready line low for BUSY_LIMIT consecutive sampled cycles (50 by default), the step ends with done and the error flag both high.
- R10: Op codes 5 to 7 are accepted, produce no strobe activity, and complete with done and error high.
- R11: Chip enable goes low when the first request is taken and stays low afterwards until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 3 | Step kind (0 cmd, 1 addr, 2 write, 3 read, 4 wait ready) |
| req_byte | input | 8 | Command, address or data byte |
| rsp_data | output | 8 | Byte captured by a read step |
| rsp_valid | output | 1 | One-cycle pulse, rsp_data valid |
| op_done | output | 1 | One-cycle pulse, step complete |
| op_err | output | 1 | With op_done: timeout or illegal op |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_oe | output | 1 | Host drives the data bus |
| nf_io_out | output | 8 | Byte driven onto the data bus |
| nf_io_in | input | 8 | Byte read from the data bus |
| nf_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
Two functions can coincide on the same clock edge: a wait step's first permitted sample of the ready line can land in the very cycle the bench model pulls that line low, and a read strobe can be requested in the same cycle its turnaround counter from the previous command or ready event expires. The bench provokes the first by delaying the model's busy phase by eight cycles after each confirm command, so a sampler that ignores the settle window finishes early and is caught by the done-time comparison; the second is judged by measuring each read fall against the preceding write-strobe rise and ready rise, and by a timeout run with the ready line held low.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [2:0] {
        OP_CMD    = 3'd0,
        OP_ADDR   = 3'd1,
        OP_WDATA  = 3'd2,
        OP_RDATA  = 3'd3,
        OP_WAITRB = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_LOW,
        S_HIGH,
        S_BUSY
    } st_e;

    typedef struct packed {
        logic       ce_n;
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       re_n;
        logic       oe;
        logic [7:0] dout;
    } bus_t;

    localparam bus_t BUS_REST = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
                                  we_n: 1'b1, re_n: 1'b1, oe: 1'b0, dout: 8'h00};

    function automatic int ns2clk(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nbs_gap_track.sv
module nbs_gap_track
    import nbs_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_rise,
    input  op_e              we_kind,
    input  logic             rdy_seen,
    output logic [CNT_W-1:0] since_we,
    output logic [CNT_W-1:0] since_rdy,
    output op_e              last_kind
);
    // Counters read as "cycles from the event edge to the coming edge",
    // saturating so an old event never wraps into a false short gap.
    always_ff @(posedge clk) begin
        if (rst) begin
            since_we  <= '1;
            since_rdy <= '1;
            last_kind <= OP_WDATA;
        end else begin
            if (we_rise) begin
                since_we  <= CNT_W'(1);
                last_kind <= we_kind;
            end else if (since_we != '1) begin
                since_we <= since_we + 1'b1;
            end
            if (rdy_seen) begin
                since_rdy <= CNT_W'(1);
            end else if (since_rdy != '1) begin
                since_rdy <= since_rdy + 1'b1;
            end
        end
    end

    a_r4_rise_restarts: assert property (@(posedge clk) disable iff (rst)
        we_rise |=> (since_we == CNT_W'(1)));

endmodule

// File: rtl/nbs_busy_watch.sv
module nbs_busy_watch #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic sample,
    input  logic rdy_in,
    output logic seen_ready,
    output logic timed_out
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] lo_cnt;

    assign seen_ready = sample && rdy_in;
    assign timed_out  = sample && !rdy_in && (lo_cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            lo_cnt <= '0;
        end else if (sample && !rdy_in && !timed_out) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        lo_cnt <= CW'(LIMIT - 1));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(seen_ready && timed_out));

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nbs_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int WP_NS      = 15,
    parameter int WH_NS      = 10,
    parameter int LS_NS      = 10,
    parameter int LH_NS      = 5,
    parameter int RP_NS      = 15,
    parameter int REH_NS     = 10,
    parameter int REA_NS     = 18,
    parameter int ADL_NS     = 100,
    parameter int WHR_NS     = 60,
    parameter int RR_NS      = 20,
    parameter int AR_NS      = 10,
    parameter int WB_NS      = 100,
    parameter int BUSY_LIMIT = 50,
    parameter int CNT_W      = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [2:0] req_op,
    input  logic [7:0] req_byte,
    output logic [7:0] rsp_data,
    output logic       rsp_valid,
    output logic       op_done,
    output logic       op_err,
    output logic       nf_ce_n,
    output logic       nf_cle,
    output logic       nf_ale,
    output logic       nf_we_n,
    output logic       nf_re_n,
    output logic       nf_io_oe,
    output logic [7:0] nf_io_out,
    input  logic [7:0] nf_io_in,
    input  logic       nf_rdy
);
    localparam int WLO_C  = imax(ns2clk(WP_NS, CLK_NS), ns2clk(LS_NS, CLK_NS));
    localparam int WHI_C  = imax(ns2clk(WH_NS, CLK_NS), ns2clk(LH_NS, CLK_NS));
    localparam int RLO_C  = imax(ns2clk(RP_NS, CLK_NS), ns2clk(REA_NS, CLK_NS));
    localparam int RHI_C  = ns2clk(REH_NS, CLK_NS);
    localparam int ADL_C  = ns2clk(ADL_NS, CLK_NS);
    localparam int RR_C   = ns2clk(RR_NS, CLK_NS);
    localparam int WB_C   = ns2clk(WB_NS, CLK_NS);
    localparam int RDA_C  = WHI_C + ns2clk(AR_NS, CLK_NS);
    localparam int RDC_C  = imax(ns2clk(WHR_NS, CLK_NS), RDA_C);

    localparam logic [CNT_W-1:0] WLO_V = CNT_W'(WLO_C);
    localparam logic [CNT_W-1:0] WHI_V = CNT_W'(WHI_C);
    localparam logic [CNT_W-1:0] RLO_V = CNT_W'(RLO_C);
    localparam logic [CNT_W-1:0] RHI_V = CNT_W'(RHI_C);
    localparam logic [CNT_W-1:0] RR_V  = CNT_W'(RR_C);
    localparam logic [CNT_W-1:0] WB_V  = CNT_W'(WB_C);
    localparam logic [CNT_W-1:0] RDA_V = CNT_W'(RDA_C);
    localparam logic [CNT_W-1:0] RDC_V = CNT_W'(RDC_C);
    localparam logic [CNT_W:0]   ADL_V = (CNT_W+1)'(ADL_C);
    localparam logic [CNT_W:0]   WLO_W = (CNT_W+1)'(WLO_C);

    st_e              st;
    op_e              op_q;
    logic [7:0]       byte_q;
    logic [CNT_W-1:0] cnt;
    bus_t             bus;

    logic [CNT_W-1:0] since_we;
    logic [CNT_W-1:0] since_rdy;
    op_e              last_kind;
    logic             we_rise;
    logic             gap_ok;
    logic             watch_arm;
    logic             watch_sample;
    logic             seen_ready;
    logic             timed_out;
    logic [CNT_W:0]   adl_sum;

    assign we_rise      = (st == S_LOW) && (cnt == '0) && (op_q != OP_RDATA);
    assign watch_arm    = (st == S_GAP) && gap_ok && (op_q == OP_WAITRB);
    assign watch_sample = (st == S_BUSY) && (since_we >= WB_V);
    assign adl_sum      = {1'b0, since_we} + WLO_W;

    // Gap the pending step must leave behind the previous bus event.
    always_comb begin
        case (op_q)
            OP_WDATA: gap_ok = (last_kind != OP_ADDR) || (adl_sum >= ADL_V);
            OP_RDATA: gap_ok = (since_rdy >= RR_V)
                            && ((last_kind != OP_CMD)  || (since_we >= RDC_V))
                            && ((last_kind != OP_ADDR) || (since_we >= RDA_V));
            default:  gap_ok = 1'b1;
        endcase
    end

    nbs_gap_track #(.CNT_W(CNT_W)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .we_rise   (we_rise),
        .we_kind   (op_q),
        .rdy_seen  (seen_ready),
        .since_we  (since_we),
        .since_rdy (since_rdy),
        .last_kind (last_kind)
    );

    nbs_busy_watch #(.LIMIT(BUSY_LIMIT)) u_busy (
        .clk        (clk),
        .rst        (rst),
        .arm        (watch_arm),
        .sample     (watch_sample),
        .rdy_in     (nf_rdy),
        .seen_ready (seen_ready),
        .timed_out  (timed_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            op_q      <= OP_CMD;
            byte_q    <= '0;
            cnt       <= '0;
            bus       <= BUS_REST;
            rsp_data  <= '0;
            rsp_valid <= 1'b0;
            op_done   <= 1'b0;
            op_err    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            op_done   <= 1'b0;
            op_err    <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q     <= op_e'(req_op);
                        byte_q   <= req_byte;
                        bus.ce_n <= 1'b0;
                        st       <= S_GAP;
                    end
                end
                S_GAP: begin
                    if (gap_ok) begin
                        case (op_q)
                            OP_CMD, OP_ADDR, OP_WDATA: begin
                                bus.we_n <= 1'b0;
                                bus.cle  <= (op_q == OP_CMD);
                                bus.ale  <= (op_q == OP_ADDR);
                                bus.oe   <= 1'b1;
                                bus.dout <= byte_q;
                                cnt      <= WLO_V - 1'b1;
                                st       <= S_LOW;
                            end
                            OP_RDATA: begin
                                bus.re_n <= 1'b0;
                                cnt      <= RLO_V - 1'b1;
                                st       <= S_LOW;
                            end
                            OP_WAITRB: st <= S_BUSY;
                            default: begin
                                op_done <= 1'b1;
                                op_err  <= 1'b1;
                                st      <= S_IDLE;
                            end
                        endcase
                    end
                end
                S_LOW: begin
                    if (cnt == '0) begin
                        if (op_q == OP_RDATA) begin
                            bus.re_n <= 1'b1;
                            rsp_data <= nf_io_in;
                            cnt      <= RHI_V - 1'b1;
                        end else begin
                            bus.we_n <= 1'b1;
                            cnt      <= WHI_V - 1'b1;
                        end
                        st <= S_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_HIGH: begin
                    if (cnt == '0) begin
                        bus.cle   <= 1'b0;
                        bus.ale   <= 1'b0;
                        bus.oe    <= 1'b0;
                        op_done   <= 1'b1;
                        rsp_valid <= (op_q == OP_RDATA);
                        st        <= S_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_BUSY: begin
                    if (seen_ready) begin
                        op_done <= 1'b1;
                        st      <= S_IDLE;
                    end else if (timed_out) begin
                        op_done <= 1'b1;
                        op_err  <= 1'b1;
                        st      <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (st == S_IDLE);
    assign nf_ce_n   = bus.ce_n;
    assign nf_cle    = bus.cle;
    assign nf_ale    = bus.ale;
    assign nf_we_n   = bus.we_n;
    assign nf_re_n   = bus.re_n;
    assign nf_io_oe  = bus.oe;
    assign nf_io_out = bus.dout;

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale));

    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    a_r4_adl_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(nf_we_n) && (op_q == OP_WDATA) && ($past(last_kind) == OP_ADDR))
            |-> ({1'b0, $past(since_we)} >= ADL_V));

    a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
        ($fell(nf_re_n) && (last_kind == OP_CMD)) |-> (since_we > RDC_V));

    a_r7_settle: assert property (@(posedge clk) disable iff (rst)
        ((st == S_BUSY) && (since_we < WB_V)) |=> (st == S_BUSY));

    a_r8_ready_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(nf_re_n) |-> (since_rdy > RR_V));

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
        op_err |-> op_done);

    a_r11_ce_holds: assert property (@(posedge clk) disable iff (rst)
        !nf_ce_n |=> !nf_ce_n);

endmodule

// File: tb/sim_nand_seq_top.sv
module sim_nand_seq_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_ready;
    logic [2:0] req_op;
    logic [7:0] req_byte;
    logic [7:0] rsp_data;
    logic       rsp_valid;
    logic       op_done;
    logic       op_err;
    logic       nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0] nf_io_out;
    logic [7:0] nf_io_in;
    logic       rb_q = 1'b1;

    always #5 clk = ~clk;

    nand_seq_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_byte(req_byte), .rsp_data(rsp_data),
        .rsp_valid(rsp_valid), .op_done(op_done), .op_err(op_err),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_oe(nf_io_oe),
        .nf_io_out(nf_io_out), .nf_io_in(nf_io_in), .nf_rdy(rb_q)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 33) & 255);
    endfunction

    // device model state
    int   rb_timer = 0;
    bit   rb_stuck = 0;
    int   rd_ptr   = 0;
    assign nf_io_in = nf_re_n ? 8'h00 : pat(rd_ptr);

    // scoreboard
    typedef struct {int kind; int val;} wr_item_t;
    wr_item_t exp_wr[$];
    int       exp_rd[$];
    int       rd_idx = 0;

    // monitor state
    logic prev_we = 1'b1, prev_re = 1'b1;
    int   we_lo = 0, re_lo = 0;
    logic lo_cle, lo_ale, lo_oe;
    logic [7:0] lo_dout;
    int   last_kind = -1, last_rise = -1000, rb_rise = -1;
    bit   done_seen = 0;
    int   done_cyc = 0;
    bit   done_err = 0;
    int   kind;
    bit   new_rb;
    wr_item_t it;

    always @(negedge clk) begin
        if (!rst) begin
            // ready/busy model
            if (rb_timer > 0) rb_timer--;
            new_rb = !rb_stuck && !(rb_timer > 0 && rb_timer <= 20);
            if (new_rb && !rb_q) rb_rise = cyc;
            rb_q = new_rb;

            if (!nf_we_n) begin
                we_lo++;
                lo_cle = nf_cle; lo_ale = nf_ale; lo_dout = nf_io_out; lo_oe = nf_io_oe;
            end
            if (nf_we_n && !prev_we) begin
                chk(we_lo == 2, "R3", "write strobe low cycles", we_lo, 2);
                kind = (lo_cle && lo_ale) ? 3 : (lo_cle ? 0 : (lo_ale ? 1 : 2));
                if (exp_wr.size() == 0) begin
                    chk(0, "R3", "unexpected write kind", kind, -1);
                end else begin
                    it = exp_wr.pop_front();
                    chk(kind == it.kind, "R3", "write latch kind", kind, it.kind);
                    chk(int'(lo_dout) == it.val, "R3", "write byte", lo_dout, it.val);
                    chk(lo_oe == 1'b1, "R3", "bus enable in write", lo_oe, 1);
                end
                chk(nf_cle == lo_cle && nf_ale == lo_ale && nf_io_out == lo_dout,
                    "R3", "latch hold after rise", {nf_cle, nf_ale}, {lo_cle, lo_ale});
                if (kind == 2 && last_kind == 1)
                    chk(cyc - last_rise >= 10, "R4", "address-to-data gap", cyc - last_rise, 10);
                if (kind == 0 && (lo_dout == 8'h30 || lo_dout == 8'h10 || lo_dout == 8'hD0))
                    rb_timer = 28;
                last_kind = kind;
                last_rise = cyc;
                we_lo = 0;
            end
            if (!nf_re_n) re_lo++;
            if (!nf_re_n && prev_re) begin
                if (last_kind == 0)
                    chk(cyc - last_rise >= 6, "R5", "command-to-read gap", cyc - last_rise, 6);
                if (rb_rise >= 0)
                    chk(cyc - rb_rise >= 2, "R8", "ready-to-read gap", cyc - rb_rise, 2);
            end
            if (nf_re_n && !prev_re) begin
                chk(re_lo == 2, "R6", "read strobe low cycles", re_lo, 2);
                re_lo = 0;
                rd_ptr++;
            end
            if (rsp_valid) begin
                if (exp_rd.size() == 0) chk(0, "R6", "unexpected read data", rsp_data, -1);
                else begin
                    int e;
                    e = exp_rd.pop_front();
                    chk(int'(rsp_data) == e, "R6", "read byte", rsp_data, e);
                    chk(op_done == 1'b1, "R6", "done with read data", op_done, 1);
                end
            end
            if (op_done) begin
                done_seen = 1;
                done_cyc  = cyc;
                done_err  = op_err;
            end
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    task automatic issue(input int op, input int val);
        @(negedge clk);
        done_seen = 0;
        req_valid = 1'b1;
        req_op    = op[2:0];
        req_byte  = val[7:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready low while step runs", req_ready, 0);
        while (!done_seen) @(negedge clk);
    endtask

    task automatic wcmd(input int v);
        exp_wr.push_back('{kind: 0, val: v});
        issue(0, v);
    endtask

    task automatic waddr(input int v);
        exp_wr.push_back('{kind: 1, val: v});
        issue(1, v);
    endtask

    task automatic wdata(input int v);
        exp_wr.push_back('{kind: 2, val: v});
        issue(2, v);
    endtask

    task automatic rdata();
        exp_rd.push_back(int'(pat(rd_idx)));
        rd_idx++;
        issue(3, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 20000) begin
                chk(0, "R7", "watchdog expired", cyc, 20000);
                wrap_up();
            end
        end
    end

    initial begin
        int conf;
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_byte = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state, R11 chip enable inactive before first request
        chk(nf_ce_n == 1'b1, "R11", "chip enable idle", nf_ce_n, 1);
        chk(nf_we_n == 1'b1 && nf_re_n == 1'b1, "R1", "strobes high", {nf_we_n, nf_re_n}, 3);
        chk(nf_cle == 1'b0 && nf_ale == 1'b0, "R1", "latches low", {nf_cle, nf_ale}, 0);
        chk(nf_io_oe == 1'b0, "R1", "bus released", nf_io_oe, 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // page read: command, four address bytes, confirm, wait
        wcmd(8'h00);
        chk(nf_ce_n == 1'b0, "R11", "chip enable after first step", nf_ce_n, 0);
        waddr(8'h12); waddr(8'h34); waddr(8'h56); waddr(8'h78);
        wcmd(8'h30);
        conf = last_rise;
        issue(4, 0);
        chk(done_err == 1'b0, "R7", "wait ends without error", done_err, 0);
        chk(done_cyc >= conf + 28, "R7", "wait not ended before busy", done_cyc - conf, 28);
        rdata(); rdata(); rdata();

        // program: address then data with the long gap
        wcmd(8'h80);
        waddr(8'h00); waddr(8'h00); waddr(8'h9A); waddr(8'hBC);
        wdata(8'hA5); wdata(8'h5A); wdata(8'hC3);
        wcmd(8'h10);
        conf = last_rise;
        issue(4, 0);
        chk(done_err == 1'b0, "R7", "program wait clean", done_err, 0);
        chk(done_cyc >= conf + 28, "R7", "program wait duration", done_cyc - conf, 28);

        // status: command then immediate read
        wcmd(8'h70);
        rdata();

        // illegal op codes
        issue(5, 0);
        chk(done_err == 1'b1, "R10", "op 5 flagged", done_err, 1);
        issue(7, 0);
        chk(done_err == 1'b1, "R10", "op 7 flagged", done_err, 1);
        chk(nf_we_n == 1'b1 && nf_re_n == 1'b1, "R10", "no strobe for illegal op",
            {nf_we_n, nf_re_n}, 3);

        // timeout: ready held low
        rb_stuck = 1;
        waddr(8'h40); waddr(8'h01);
        wcmd(8'hD0);
        conf = last_rise;
        issue(4, 0);
        chk(done_err == 1'b1, "R9", "busy timeout error", done_err, 1);
        chk(done_cyc - conf >= 59, "R9", "timeout not premature", done_cyc - conf, 59);
        rb_stuck = 0;

        // recovery after timeout
        repeat (30) @(negedge clk);
        wcmd(8'hFF);
        issue(4, 0);
        chk(done_err == 1'b0, "R7", "wait after recovery", done_err, 0);
        chk(exp_wr.size() == 0, "R3", "all writes seen", exp_wr.size(), 0);
        chk(exp_rd.size() == 0, "R6", "all reads seen", exp_rd.size(), 0);
        chk(nf_ce_n == 1'b0, "R11", "chip enable held", nf_ce_n, 0);

        repeat (5) @(negedge clk);
        wrap_up();
    end

endmodule